// File: doc/BRIEF.md
# Serial Port Register and FIFO Frontend

This block sits between a simple register bus and the bit-level serializer of a fixed-format serial port. Software sees five 32-bit word registers: a data port, a FIFO fill-level word, an interrupt status word, a control word and a baud divisor. Bytes written to the data port enter a 64-entry transmit queue that the serializer drains one byte at a time. Bytes the serializer receives are pushed, with their framing-error and break flags, into a 64-entry receive queue that software reads through the same data port.

Each receive read returns the byte together with an empty flag and the two per-byte error flags. The frontend raises a receive interrupt when the receive queue reaches a selectable threshold, or when bytes have sat in it for a selectable number of character times with no traffic. It raises a transmit interrupt when the transmit queue drains to a selectable low-water mark. Framing errors, breaks and receive overruns are latched and cleared by writing ones. A single interrupt line combines all sources under three enables.

Top module: `uart_regfront`

## Requirements
- R1: Register byte offsets are 0x00 data, 0x04 level, 0x08 status, 0x0C control, 0x10 rate; after reset control, rate and status read as zero. The rate register keeps the low 8 bits of a write; control keeps only bits 17:16, 8:5 and 4:0, other bits read zero.
- R2: A data read with a non-empty receive queue returns the oldest byte in bits 7:0, its framing-error flag in bit 9 and its break flag in bit 10, bit 8 clear, and removes it; with an empty queue it returns 0x100 and removes nothing.
- R3: The level register returns the receive queue count in bits 7:0 and the transmit queue count in bits 15:8.
- R4: Each queue holds 64 entries in first-in first-out order; the serializer side sees the transmit head byte and a valid flag, and takes it with a one-cycle take pulse.
- R5: Status bit 1 reads 1 exactly while the receive count is at least the threshold chosen by control bits 4:2: codes 0..5 give 1, 4, 8, 16, 32, 48; codes 6 and 7 also give 48.
- R6: Status bit 2 reads 1 when control bits 17:16 are nonzero, the receive queue is not empty, and at least 4, 8 or 16 (codes 1, 2, 3) character-time pulses have arrived since the last receive push or pop; code 0 never sets it, and a push or pop clears it.
- R7: A data write while the transmit queue is full is dropped; the queue contents are unchanged.
- R8: A received byte arriving while the receive queue is full is discarded and sets latched status bit 5.
- R9: A received byte with its framing-error flag sets latched status bit 3, one with its break flag sets latched status bit 4; writing 1 to bit 3, 4 or 5 of the status register clears that bit only.
- R10: Latched status bit 0 sets when a take leaves the transmit count equal to the level chosen by control bits 1:0 (codes 0..3 give 0, 4, 8, 16), or when software writes 1 to status bit 6; writing 1 to bit 0 clears it; bit 6 reads zero.
- R11: The interrupt output is status bit 0 gated by control bit 5, bits 1 or 2 gated by control bit 6, and bits 3, 4 or 5 gated by control bit 7, all ORed.
- R12: Control bit 8 drives the forced-break output, and the rate register drives the divisor output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue on a data read) |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the strobe cycle |
| txq_byte | output | 8 | Transmit queue head byte |
| txq_valid | output | 1 | Transmit queue not empty |
| txq_take | input | 1 | Serializer takes the head byte |
| rxq_byte | input | 8 | Received byte |
| rxq_ferr | input | 1 | Framing error on the received byte |
| rxq_brk | input | 1 | Received byte is a break |
| rxq_push | input | 1 | Received byte strobe |
| char_tick | input | 1 | One pulse per character time on the line |
| rate_div | output | 8 | Baud divisor for the serializer |
| line_break | output | 1 | Force the transmit line to break |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are the queue edges: a receive overrun needs 65 received bytes before any read, and the receive timeout needs bytes parked in the queue while the line stays quiet for an exact number of character times. The bench drives the serializer handshake directly, pushing 66 bytes back to back and then pacing the character-time pulse one at a time, checking the timeout bit after every pulse for each code. Threshold codes are swept exhaustively, with the status bit checked after every single push or take.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_DATA  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_LEVEL = 5'h04;
  localparam logic [REG_AW-1:0] OFS_STS   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_RATE  = 5'h10;

  localparam int ST_TX    = 0;
  localparam int ST_FE    = 3;
  localparam int ST_BRK   = 4;
  localparam int ST_OE    = 5;
  localparam int ST_TXSET = 6;

  typedef struct packed {
    logic [1:0] tmo_sel;
    logic       brk_force;
    logic       err_en;
    logic       rx_en;
    logic       tx_en;
    logic [2:0] rx_lvl;
    logic [1:0] tx_lvl;
  } ctrl_t;

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    return {14'd0, c.tmo_sel, 7'd0, c.brk_force, c.err_en, c.rx_en, c.tx_en,
            c.rx_lvl, c.tx_lvl};
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.tmo_sel   = w[17:16];
    c.brk_force = w[8];
    c.err_en    = w[7];
    c.rx_en     = w[6];
    c.tx_en     = w[5];
    c.rx_lvl    = w[4:2];
    c.tx_lvl    = w[1:0];
    return c;
  endfunction

  // Receive threshold in bytes for a 3-bit code.
  function automatic int rx_thr(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 48;
    endcase
  endfunction

  // Transmit low-water mark in bytes for a 2-bit code.
  function automatic int tx_thr(input logic [1:0] code);
    return (code == 2'd0) ? 0 : (2 << code);
  endfunction

  // Idle character times before a receive timeout (code 0 unused).
  function automatic int tmo_lim(input logic [1:0] code);
    return 2 << code;
  endfunction

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/uart_rf_rxtmo.sv
module uart_rf_rxtmo
  import uart_rf_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  input  logic       fifo_empty,
  input  logic       activity,
  input  logic       char_tick,
  output logic       hit
);
  logic [CNT_W-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (fifo_empty || activity) begin
      idle_q <= '0;
    end else if (char_tick && (idle_q != '1)) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign hit = (code != 2'd0) && !fifo_empty && (int'(idle_q) >= tmo_lim(code));
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int TMO_CW     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  txq_byte,
  output logic        txq_valid,
  input  logic        txq_take,
  input  logic [7:0]  rxq_byte,
  input  logic        rxq_ferr,
  input  logic        rxq_brk,
  input  logic        rxq_push,
  input  logic        char_tick,
  output logic [7:0]  rate_div,
  output logic        line_break,
  output logic        irq
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  ctrl_t       ctrl_q;
  logic [7:0]  rate_q;
  logic        sts_tx_q, sts_fe_q, sts_brk_q, sts_oe_q;

  // named internal events
  logic          tx_push_req, tx_full_w, tx_empty_w, tx_take_ok, tx_push_ok;
  logic          rx_pop_req, rx_full_w, rx_empty_w;
  logic [CW-1:0] tx_cnt_w, rx_cnt_w;
  logic [9:0]    rx_head;
  logic          rx_trig, tmo_hit, tx_low_hit, sts_wr;

  assign tx_push_req = bus_wr && (bus_addr == OFS_DATA);
  assign rx_pop_req  = bus_rd && (bus_addr == OFS_DATA);
  assign sts_wr      = bus_wr && (bus_addr == OFS_STS);
  assign tx_take_ok  = txq_take && !tx_empty_w;
  assign tx_push_ok  = tx_push_req && !tx_full_w;

  uart_rf_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push_req), .din(bus_wdata[7:0]),
    .pop(txq_take), .dout(txq_byte),
    .count(tx_cnt_w), .full(tx_full_w), .empty(tx_empty_w)
  );

  uart_rf_fifo #(.W(10), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rxq_push), .din({rxq_brk, rxq_ferr, rxq_byte}),
    .pop(rx_pop_req), .dout(rx_head),
    .count(rx_cnt_w), .full(rx_full_w), .empty(rx_empty_w)
  );

  uart_rf_rxtmo #(.CNT_W(TMO_CW)) u_tmo (
    .clk(clk), .rst_n(rst_n),
    .code(ctrl_q.tmo_sel), .fifo_empty(rx_empty_w),
    .activity(rxq_push || rx_pop_req), .char_tick(char_tick),
    .hit(tmo_hit)
  );

  assign txq_valid  = !tx_empty_w;
  assign rx_trig    = int'(rx_cnt_w) >= rx_thr(ctrl_q.rx_lvl);
  assign tx_low_hit = tx_take_ok && !tx_push_ok &&
                      ((int'(tx_cnt_w) - 1) == tx_thr(ctrl_q.tx_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rate_q    <= '0;
      sts_tx_q  <= 1'b0;
      sts_fe_q  <= 1'b0;
      sts_brk_q <= 1'b0;
      sts_oe_q  <= 1'b0;
    end else begin
      if (bus_wr && (bus_addr == OFS_CTRL)) ctrl_q <= ctrl_unpack(bus_wdata);
      if (bus_wr && (bus_addr == OFS_RATE)) rate_q <= bus_wdata[7:0];
      sts_tx_q  <= (sts_tx_q && !(sts_wr && bus_wdata[ST_TX])) || tx_low_hit ||
                   (sts_wr && bus_wdata[ST_TXSET]);
      sts_fe_q  <= (sts_fe_q && !(sts_wr && bus_wdata[ST_FE])) || (rxq_push && rxq_ferr);
      sts_brk_q <= (sts_brk_q && !(sts_wr && bus_wdata[ST_BRK])) || (rxq_push && rxq_brk);
      sts_oe_q  <= (sts_oe_q && !(sts_wr && bus_wdata[ST_OE])) || (rxq_push && rx_full_w);
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DATA:  bus_rdata = rx_empty_w ? 32'h0000_0100
                           : {21'd0, rx_head[9], rx_head[8], 1'b0, rx_head[7:0]};
      OFS_LEVEL: bus_rdata = {16'd0, 8'(tx_cnt_w), 8'(rx_cnt_w)};
      OFS_STS:   bus_rdata = {25'd0, 1'b0, sts_oe_q, sts_brk_q, sts_fe_q,
                              tmo_hit, rx_trig, sts_tx_q};
      OFS_CTRL:  bus_rdata = ctrl_pack(ctrl_q);
      OFS_RATE:  bus_rdata = {24'd0, rate_q};
      default:   bus_rdata = 32'd0;
    endcase
  end

  assign rate_div   = rate_q;
  assign line_break = ctrl_q.brk_force;
  assign irq        = (sts_tx_q && ctrl_q.tx_en) ||
                      ((rx_trig || tmo_hit) && ctrl_q.rx_en) ||
                      ((sts_fe_q || sts_brk_q || sts_oe_q) && ctrl_q.err_en);
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
  import uart_rf_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CW = $clog2(FIFO_DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [4:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          txq_take,
  input logic          rxq_push,
  input logic          tx_push_req,
  input logic          tx_full_w,
  input logic          rx_full_w,
  input logic [CW-1:0] tx_cnt_w,
  input logic [CW-1:0] rx_cnt_w,
  input logic          tmo_hit,
  input logic          sts_fe_q,
  input logic          sts_oe_q
);
  a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt_w <= CW'(FIFO_DEPTH)) && (tx_cnt_w <= CW'(FIFO_DEPTH)));

  a_r7_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_req && tx_full_w && !txq_take) |=> $stable(tx_cnt_w));

  a_r8_overrun_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_push && rx_full_w) |=> sts_oe_q);

  a_r9_fe_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_STS) && bus_wdata[ST_FE] && !rxq_push) |=> !sts_fe_q);

  a_r6_no_timeout_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt_w == '0) |-> !tmo_hit);
endmodule

bind uart_regfront uart_regfront_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .txq_take(txq_take), .rxq_push(rxq_push),
  .tx_push_req(tx_push_req), .tx_full_w(tx_full_w), .rx_full_w(rx_full_w),
  .tx_cnt_w(tx_cnt_w), .rx_cnt_w(rx_cnt_w), .tmo_hit(tmo_hit),
  .sts_fe_q(sts_fe_q), .sts_oe_q(sts_oe_q)
);

// File: tb/test_uart_regfront.sv
module test_uart_regfront;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_DATA = 5'h00, A_LVL = 5'h04, A_STS = 5'h08,
                         A_CTRL = 5'h0C, A_RATE = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0, txq_take = 0, rxq_ferr = 0, rxq_brk = 0;
  logic rxq_push = 0, char_tick = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  rxq_byte = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  txq_byte, rate_div;
  logic        txq_valid, line_break, irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfront i_uart_regfront (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txq_byte(txq_byte), .txq_valid(txq_valid), .txq_take(txq_take),
    .rxq_byte(rxq_byte), .rxq_ferr(rxq_ferr), .rxq_brk(rxq_brk),
    .rxq_push(rxq_push), .char_tick(char_tick), .rate_div(rate_div),
    .line_break(line_break), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rxin(input logic [7:0] b, input logic fe, input logic bk);
    @(negedge clk); rxq_push = 1; rxq_byte = b; rxq_ferr = fe; rxq_brk = bk;
    @(negedge clk); rxq_push = 0; rxq_ferr = 0; rxq_brk = 0;
  endtask

  task automatic take();
    @(negedge clk); txq_take = 1;
    @(negedge clk); txq_take = 0;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  task automatic drain_rx();
    logic [31:0] v;
    rd(A_LVL, v);
    for (int k = 0; k < int'(v[7:0]); k++) rd(A_DATA, r);
  endtask

  task automatic drain_tx();
    while (txq_valid) take();
  endtask

  function automatic int exp_rx_thr(input int c);
    if (c == 0) return 1;
    if (c >= 5) return 48;
    return 4 << (c - 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_CTRL, r); chk("R1 ctrl reset", r, 32'h0);
    rd(A_RATE, r); chk("R1 rate reset", r, 32'h0);
    rd(A_STS, r);  chk("R1 status reset", r, 32'h0);
    rd(A_LVL, r);  chk("R3 level reset", r, 32'h0);
    rd(A_DATA, r); chk("R2 empty read", r, 32'h100);
    chk("R11 irq reset", {31'd0, irq}, 32'd0);

    // R1 register masks
    wr(A_RATE, 32'h0000_01A5); rd(A_RATE, r); chk("R1 rate mask", r, 32'hA5);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, r); chk("R1 ctrl mask", r, 32'h0003_01FF);
    wr(A_CTRL, 32'h0);
    wr(A_STS, 32'h0000_0001);

    // R12 outputs
    chk("R12 rate out", {24'd0, rate_div}, 32'hA5);
    wr(A_CTRL, 32'h100); chk("R12 break on", {31'd0, line_break}, 32'd1);
    wr(A_CTRL, 32'h0);   chk("R12 break off", {31'd0, line_break}, 32'd0);

    // R2 / R9 read word format and error latches
    rxin(8'h5A, 1, 0); rxin(8'h3C, 0, 1); rxin(8'hFF, 1, 1);
    rd(A_STS, r); chk("R9 fe+brk latched", r & 32'h18, 32'h18);
    wr(A_STS, 32'h08); rd(A_STS, r); chk("R9 clear fe only", r & 32'h38, 32'h10);
    wr(A_STS, 32'h10); rd(A_STS, r); chk("R9 clear brk", r & 32'h38, 32'h00);
    rd(A_DATA, r); chk("R2 word fe", r, 32'h25A);
    rd(A_DATA, r); chk("R2 word brk", r, 32'h43C);
    rd(A_DATA, r); chk("R2 word both", r, 32'h6FF);
    rd(A_DATA, r); chk("R2 empty again", r, 32'h100);
    rd(A_LVL, r);  chk("R2 empty read no pop", r, 32'h0);

    // R3 level
    for (int i = 0; i < 3; i++) rxin(8'(i), 0, 0);
    for (int i = 0; i < 5; i++) wr(A_DATA, 32'(i));
    rd(A_LVL, r); chk("R3 level both", r, 32'h0503);
    drain_rx(); drain_tx(); wr(A_STS, 32'h1);

    // R5 receive threshold sweep
    for (int c = 0; c < 8; c++) begin
      wr(A_CTRL, 32'(c) << 2);
      for (int n = 1; n <= 50; n++) begin
        rxin(8'(n), 0, 0);
        rd(A_STS, r);
        chk($sformatf("R5 trig code%0d n%0d", c, n), {31'd0, r[1]},
            {31'd0, n >= exp_rx_thr(c)});
      end
      drain_rx();
      rd(A_STS, r); chk("R5 trig after drain", {31'd0, r[1]}, 32'd0);
    end

    // R10 transmit low-water sweep
    for (int c = 0; c < 4; c++) begin
      int thr;
      thr = (c == 0) ? 0 : (1 << (c + 1));
      wr(A_CTRL, 32'(c));
      for (int i = 0; i < 20; i++) wr(A_DATA, 32'(i + 8'h80));
      for (int k = 20; k > 0; k--) begin
        chk("R4 tx order", {24'd0, txq_byte}, 32'(8'h80 + 20 - k));
        take();
        rd(A_STS, r);
        chk($sformatf("R10 tx code%0d cnt%0d", c, k - 1), {31'd0, r[0]},
            {31'd0, (k - 1) == thr});
        if (r[0]) begin
          wr(A_STS, 32'h1); rd(A_STS, r); chk("R10 tx w1c", {31'd0, r[0]}, 32'd0);
        end
      end
    end
    wr(A_STS, 32'h40); rd(A_STS, r); chk("R10 sw set", r & 32'h41, 32'h01);
    wr(A_STS, 32'h01); rd(A_STS, r); chk("R10 sw clear", r & 32'h41, 32'h00);

    // R7 / R4 transmit overflow
    wr(A_CTRL, 32'h0);
    for (int i = 0; i < 70; i++) wr(A_DATA, 32'(i + 64));
    rd(A_LVL, r); chk("R7 tx level capped", r, 32'h4000);
    for (int i = 0; i < 64; i++) begin
      chk("R7 tx kept bytes", {24'd0, txq_byte}, 32'(8'(i + 64)));
      take();
    end
    chk("R7 tx empty after", {31'd0, txq_valid}, 32'd0);
    wr(A_STS, 32'h1);

    // R8 / R4 receive overrun
    for (int i = 0; i < 66; i++) rxin(8'(i), 0, 0);
    rd(A_LVL, r); chk("R8 rx level capped", r, 32'h0040);
    rd(A_STS, r); chk("R8 overrun set", r & 32'h20, 32'h20);
    wr(A_STS, 32'h20); rd(A_STS, r); chk("R8 overrun clear", r & 32'h20, 32'h0);
    for (int i = 0; i < 64; i++) begin
      rd(A_DATA, r); chk("R4 rx order", r, 32'(i));
    end
    rd(A_DATA, r); chk("R8 excess discarded", r, 32'h100);

    // R6 receive timeout
    for (int c = 1; c < 4; c++) begin
      int lim;
      lim = 4 << (c - 1);
      wr(A_CTRL, 32'(c) << 16);
      rxin(8'h11, 0, 0);
      for (int t = 1; t <= lim + 2; t++) begin
        tick(); rd(A_STS, r);
        chk($sformatf("R6 tmo code%0d t%0d", c, t), {31'd0, r[2]}, {31'd0, t >= lim});
      end
      rxin(8'h22, 0, 0);
      rd(A_STS, r); chk("R6 push clears", {31'd0, r[2]}, 32'd0);
      for (int t = 1; t < lim; t++) tick();
      rd(A_STS, r); chk("R6 below limit", {31'd0, r[2]}, 32'd0);
      drain_rx();
      tick(); rd(A_STS, r); chk("R6 empty no tmo", {31'd0, r[2]}, 32'd0);
    end
    wr(A_CTRL, 32'h0);
    rxin(8'h33, 0, 0);
    for (int t = 0; t < 20; t++) tick();
    rd(A_STS, r); chk("R6 code0 off", {31'd0, r[2]}, 32'd0);

    // R11 interrupt gating
    chk("R11 rx masked", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'h40); chk("R11 rx enabled", {31'd0, irq}, 32'd1);
    drain_rx();         chk("R11 rx drained", {31'd0, irq}, 32'd0);
    rxin(8'h44, 1, 0); rd(A_DATA, r);
    chk("R11 err masked", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'h80); chk("R11 err enabled", {31'd0, irq}, 32'd1);
    wr(A_STS, 32'h08);  chk("R11 err cleared", {31'd0, irq}, 32'd0);
    wr(A_STS, 32'h40);  chk("R11 tx masked", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'h20); chk("R11 tx enabled", {31'd0, irq}, 32'd1);
    wr(A_STS, 32'h01);  chk("R11 tx cleared", {31'd0, irq}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule